// File: doc/BRIEF.md
# Three-Stream Strided Address Generator

This block is the only path between a loop accelerator and memory. It runs up to three array streams in step. Each stream has its own base address, signed stride and enable. For every loop iteration it reads one element from each enabled read stream and places that element in a fixed operand register. Stream 0 feeds operand register 0, stream 1 feeds register 1 and stream 2 feeds register 2. These registers drive the configurable logic and the multiply-accumulate unit. One of the streams may instead be chosen as the write stream. That stream stores the accelerator's result once per iteration.

Software fills in the configuration through a small register write port before the loop starts. The loop controller pulses `start_i` to begin. It then pulses `step_i` once per iteration, after it has used the operands. Memory is one single-port synchronous RAM with a read latency of one cycle. The reads of an iteration therefore go out one per cycle in stream order. The operand registers are flagged valid only when the whole set has been loaded.

Top module: `tri_stream_agu`

## Requirements
- R1: While `rst_ni` is low, and after it is released until the next start, `busy_o`, `valid_o`, `done_o`, `mem_req_o` and `mem_we_o` are 0 and all three operand registers read 0.
- R2: In iteration i (counting from 0), stream s uses address base_s + i*stride_s. The stride is a two's-complement value and the sum wraps modulo 2^AW.
- R3: After an accepted start or step there is a fetch window of three cycles. In cycle k (k = 0, 1, 2) of the window, `mem_req_o` is high with `mem_we_o` low exactly when stream k is a read stream, and `mem_addr_o` then carries that stream's address. A read stream is enabled and is not the write stream.
- R4: The word read for stream k is loaded into operand register k. The register of a stream that is disabled or is the write stream keeps its previous value.
- R5: `valid_o` rises on the fourth clock edge after the edge that accepts a start or step. It stays high until the edge that accepts `step_i`, and it falls on that edge.
- R6: Field write-select 0, 1 or 2 makes that stream the write stream, and 3 means there is none. While `valid_o` and `step_i` are both high and the write stream is enabled, the port performs one write in that same cycle. The write puts `wr_data_i` at the write stream's address for the current iteration.
- R7: `start_i` has no effect while `busy_o` is high. `step_i` has no effect while `valid_o` is low.
- R8: The step that ends iteration count-1 starts no fetch. On the next cycle `done_o` is high for exactly one cycle, and after that `busy_o` is low. A start with count 0 is ignored.
- R9: Configuration map on `cfg_addr_i`. Bits [3:2] equal to 0, 1 or 2 select a stream, and then bits [1:0] pick base (0), stride (1) or enable (2, data bit 0). Bits [3:2] equal to 3 select the globals, where [1:0] = 0 is the iteration count and [1:0] = 1 is write-select (data bits [1:0], reset value 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 4 | Configuration register select |
| cfg_wdata_i | input | 32 | Configuration write data |
| start_i | input | 1 | Begin the loop at iteration 0 |
| step_i | input | 1 | Operands consumed; write and advance |
| wr_data_i | input | DW | Result stored by the write stream |
| busy_o | output | 1 | Loop in progress |
| valid_o | output | 1 | Operand registers hold the current iteration |
| done_o | output | 1 | One-cycle pulse after the last iteration |
| reg0_o | output | DW | Operand register of stream 0 |
| reg1_o | output | DW | Operand register of stream 1 |
| reg2_o | output | DW | Operand register of stream 2 |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Read data, one cycle after the request |

## Verification
The properties assume that `step_i` is a one-cycle pulse asserted only when the controller intends to advance. They also assume that configuration writes happen only while the block is idle, and that the memory answers every read on the next cycle. The bench keeps to these limits. It writes all configuration between loops and drives each strobe for a single cycle on a falling edge. Its memory model returns a word derived from the address one cycle after each read. In one directed case it deliberately raises `start_i` and `step_i` during a fetch window, to show that both are ignored there.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int NS    = 3;
  localparam int PTR_W = 2;
  localparam logic [1:0] WSEL_NONE = 2'd3;

  localparam logic [1:0] OFS_BASE   = 2'd0;
  localparam logic [1:0] OFS_STRIDE = 2'd1;
  localparam logic [1:0] OFS_EN     = 2'd2;
  localparam logic [1:0] GRP_GLOBAL = 2'd3;
  localparam logic [1:0] OFS_COUNT  = 2'd0;
  localparam logic [1:0] OFS_WSEL   = 2'd1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_DRAIN, ST_READY, ST_DONE
  } agu_state_e;
endpackage

// File: rtl/agu_cfg_regs.sv
module agu_cfg_regs
  import agu_pkg::*;
#(
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int CFG_W = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [3:0]             addr_i,
  input  logic [CFG_W-1:0]       wdata_i,
  output logic [NS-1:0][AW-1:0]  base_o,
  output logic [NS-1:0][AW-1:0]  stride_o,
  output logic [NS-1:0]          en_o,
  output logic [CW-1:0]          count_o,
  output logic [1:0]             wsel_o
);
  logic [1:0] grp, ofs;
  assign grp = addr_i[3:2];
  assign ofs = addr_i[1:0];

  logic unused_hi;
  assign unused_hi = ^wdata_i[CFG_W-1:AW];

  for (genvar s = 0; s < NS; s++) begin : g_strm
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_o[s]   <= '0;
        stride_o[s] <= '0;
        en_o[s]     <= 1'b0;
      end else if (we_i && grp == 2'(s)) begin
        case (ofs)
          OFS_BASE:   base_o[s]   <= wdata_i[AW-1:0];
          OFS_STRIDE: stride_o[s] <= wdata_i[AW-1:0];
          OFS_EN:     en_o[s]     <= wdata_i[0];
          default:    ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '0;
      wsel_o  <= WSEL_NONE;
    end else if (we_i && grp == GRP_GLOBAL) begin
      case (ofs)
        OFS_COUNT: count_o <= wdata_i[CW-1:0];
        OFS_WSEL:  wsel_o  <= wdata_i[1:0];
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/agu_stream_ptr.sv
module agu_stream_ptr #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          adv_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] stride_i,
  output logic [AW-1:0] addr_o
);
  // running sum replaces base + i*stride; two's-complement add covers negative strides
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_o <= '0;
    else if (load_i) addr_o <= base_i;
    else if (adv_i)  addr_o <= addr_o + stride_i;
  end
endmodule

// File: rtl/agu_seq.sv
module agu_seq
  import agu_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             step_i,
  input  logic [CW-1:0]    count_i,
  input  logic [NS-1:0]    en_i,
  input  logic [1:0]       wsel_i,
  output logic             load_o,
  output logic             adv_o,
  output logic             rd_req_o,
  output logic [PTR_W-1:0] rd_idx_o,
  output logic             wr_req_o,
  output logic             cap_o,
  output logic [PTR_W-1:0] cap_idx_o,
  output logic             valid_o,
  output logic             busy_o,
  output logic             done_o
);
  agu_state_e       state_q, state_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [CW-1:0]    iter_q, iter_d;
  logic             pend_q;
  logic [PTR_W-1:0] pend_idx_q;
  logic [3:0]       en_pad;
  logic             start_ok, step_ok, last_iter, rd_active;

  assign en_pad    = 4'(en_i);
  assign start_ok  = (state_q == ST_IDLE) && start_i && (count_i != '0);
  assign step_ok   = (state_q == ST_READY) && step_i;
  assign last_iter = (iter_q == count_i - 1'b1);
  assign rd_active = en_pad[ptr_q] && (wsel_i != ptr_q);

  assign load_o    = start_ok;
  assign adv_o     = step_ok;
  assign rd_req_o  = (state_q == ST_FETCH) && rd_active;
  assign rd_idx_o  = ptr_q;
  assign wr_req_o  = step_ok && (wsel_i != WSEL_NONE) && en_pad[wsel_i];
  assign cap_o     = pend_q;
  assign cap_idx_o = pend_idx_q;
  assign valid_o   = (state_q == ST_READY);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    iter_d  = iter_q;
    case (state_q)
      ST_IDLE: if (start_ok) begin
        state_d = ST_FETCH;
        ptr_d   = '0;
        iter_d  = '0;
      end
      ST_FETCH: begin
        if (ptr_q == PTR_W'(NS - 1)) state_d = ST_DRAIN;
        else                         ptr_d   = ptr_q + 1'b1;
      end
      ST_DRAIN: state_d = ST_READY;
      ST_READY: if (step_ok) begin
        if (last_iter) state_d = ST_DONE;
        else begin
          state_d = ST_FETCH;
          ptr_d   = '0;
          iter_d  = iter_q + 1'b1;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      ptr_q      <= '0;
      iter_q     <= '0;
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
    end else begin
      state_q    <= state_d;
      ptr_q      <= ptr_d;
      iter_q     <= iter_d;
      pend_q     <= rd_req_o;
      pend_idx_q <= ptr_q;
    end
  end
endmodule

// File: rtl/tri_stream_agu.sv
module tri_stream_agu
  import agu_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int CW    = 16,
  parameter int CFG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [3:0]       cfg_addr_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             start_i,
  input  logic             step_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic             busy_o,
  output logic             valid_o,
  output logic             done_o,
  output logic [DW-1:0]    reg0_o,
  output logic [DW-1:0]    reg1_o,
  output logic [DW-1:0]    reg2_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic [DW-1:0]    mem_rdata_i
);
  logic [NS-1:0][AW-1:0] base, stride, cur_addr;
  logic [NS-1:0]         en;
  logic [CW-1:0]         count;
  logic [1:0]            wsel;
  logic                  load, adv, rd_req, wr_req, cap;
  logic [PTR_W-1:0]      rd_idx, cap_idx;
  logic [NS-1:0][DW-1:0] opnd_q;

  agu_cfg_regs #(.AW(AW), .CW(CW), .CFG_W(CFG_W)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .base_o(base), .stride_o(stride), .en_o(en),
    .count_o(count), .wsel_o(wsel)
  );

  agu_seq #(.CW(CW)) u_seq (
    .clk_i, .rst_ni, .start_i, .step_i,
    .count_i(count), .en_i(en), .wsel_i(wsel),
    .load_o(load), .adv_o(adv),
    .rd_req_o(rd_req), .rd_idx_o(rd_idx), .wr_req_o(wr_req),
    .cap_o(cap), .cap_idx_o(cap_idx),
    .valid_o, .busy_o, .done_o
  );

  for (genvar s = 0; s < NS; s++) begin : g_strm
    agu_stream_ptr #(.AW(AW)) u_ptr (
      .clk_i, .rst_ni,
      .load_i(load), .adv_i(adv),
      .base_i(base[s]), .stride_i(stride[s]),
      .addr_o(cur_addr[s])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        opnd_q[s] <= '0;
      else if (cap && cap_idx == 2'(s))   opnd_q[s] <= mem_rdata_i;
    end
  end

  // write and reads never share a cycle: write only in READY, reads only in FETCH
  always_comb begin
    mem_addr_o = '0;
    for (int s = 0; s < NS; s++) begin
      if (wr_req && wsel == 2'(s))        mem_addr_o = cur_addr[s];
      else if (!wr_req && rd_idx == 2'(s)) mem_addr_o = cur_addr[s];
    end
  end

  assign mem_req_o   = rd_req | wr_req;
  assign mem_we_o    = wr_req;
  assign mem_wdata_o = wr_data_i;
  assign reg0_o      = opnd_q[0];
  assign reg1_o      = opnd_q[1];
  assign reg2_o      = opnd_q[2];
endmodule

// File: rtl/tri_stream_agu_chk.sv
module tri_stream_agu_chk #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          step_i,
  input logic          busy_o,
  input logic          valid_o,
  input logic          done_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [DW-1:0] wr_data_i,
  input logic [DW-1:0] mem_wdata_o
);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !valid_o && !done_o);

  a_r3_no_read_when_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !(mem_req_o && !mem_we_o));

  a_r5_valid_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !step_i |=> valid_o);

  a_r5_valid_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && step_i |=> !valid_o);

  a_r6_write_on_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_req_o && step_i && valid_o && (mem_wdata_o == wr_data_i));

  a_r7_idle_stays_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> !busy_o);

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);

  a_r8_done_after_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(valid_o && step_i));
endmodule

bind tri_stream_agu tri_stream_agu_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .step_i(step_i),
  .busy_o(busy_o), .valid_o(valid_o), .done_o(done_o),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .wr_data_i(wr_data_i), .mem_wdata_o(mem_wdata_o)
);

// File: tb/tri_stream_agu_tb_top.sv
`timescale 1ns/1ps
module tri_stream_agu_tb_top;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [3:0]    cfg_addr_i = '0;
  logic [31:0]   cfg_wdata_i = '0;
  logic          start_i = 1'b0, step_i = 1'b0;
  logic [DW-1:0] wr_data_i = '0;
  logic          busy_o, valid_o, done_o, mem_req_o, mem_we_o;
  logic [DW-1:0] reg0_o, reg1_o, reg2_o, mem_wdata_o;
  logic [DW-1:0] mem_rdata_i = '0;
  logic [AW-1:0] mem_addr_o;

  always #2.5 clk = ~clk;

  tri_stream_agu dut_i (
    .clk_i(clk), .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .start_i, .step_i, .wr_data_i, .busy_o, .valid_o, .done_o,
    .reg0_o, .reg1_o, .reg2_o, .mem_req_o, .mem_we_o, .mem_addr_o,
    .mem_wdata_o, .mem_rdata_i
  );

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return {16'hA5C3, a};
  endfunction

  always_ff @(posedge clk) if (mem_req_o && !mem_we_o) mem_rdata_i <= mem_word(mem_addr_o);

  int compared = 0, mismatched = 0;
  logic [DW-1:0] exp_reg [3] = '{default: '0};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] ea(input logic [15:0] b, input logic [15:0] s, input int i);
    return AW'(int'(b) + i * int'($signed(s)));
  endfunction

  typedef struct packed {
    logic [15:0] b0, s0, b1, s1, b2, s2;
    logic [2:0]  en;
    logic [1:0]  ws;
    logic [7:0]  cnt;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{16'h0100, 16'h0001, 16'h0200, 16'h0002, 16'h0300, 16'h0004, 3'b111, 2'd3, 8'd3},
    '{16'h1000, 16'hFFFF, 16'h2000, 16'h0010, 16'h4000, 16'h0003, 3'b111, 2'd2, 8'd4},
    '{16'hFFFE, 16'h0001, 16'h0AAA, 16'h0001, 16'h0050, 16'hFFFC, 3'b101, 2'd3, 8'd3},
    '{16'h0010, 16'h0000, 16'h0700, 16'h0008, 16'h0900, 16'h0001, 3'b011, 2'd0, 8'd2}
  };

  task automatic cfg_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input bit poke);
    logic [15:0] b [3];
    logic [15:0] s [3];
    bit rd [3];
    bit wr_en;
    b = '{v.b0, v.b1, v.b2};
    s = '{v.s0, v.s1, v.s2};
    for (int k = 0; k < 3; k++) begin
      cfg_wr(4'(k * 4 + 0), 32'(b[k]));
      cfg_wr(4'(k * 4 + 1), 32'(s[k]));
      cfg_wr(4'(k * 4 + 2), 32'(v.en[k]));
      rd[k] = v.en[k] && (v.ws != 2'(k));
    end
    cfg_wr(4'd12, 32'(v.cnt));
    cfg_wr(4'd13, 32'(v.ws));
    wr_en = (v.ws != 2'd3) && v.en[v.ws];
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    for (int i = 0; i < int'(v.cnt); i++) begin
      for (int k = 0; k < 5; k++) begin
        if (k > 0) @(negedge clk);
        if (k < 3) begin
          check("R3 read request", 64'(mem_req_o && !mem_we_o), 64'(rd[k]));
          if (rd[k]) check("R2 read address", 64'(mem_addr_o), 64'(ea(b[k], s[k], i)));
        end
        if (k == 3) check("R5 valid low before fourth edge", 64'(valid_o), 64'd0);
        if (k == 4) begin
          for (int q = 0; q < 3; q++) if (rd[q]) exp_reg[q] = mem_word(ea(b[q], s[q], i));
          check("R5 valid on fourth edge", 64'(valid_o), 64'd1);
          check("R4 reg0", 64'(reg0_o), 64'(exp_reg[0]));
          check("R4 reg1", 64'(reg1_o), 64'(exp_reg[1]));
          check("R4 reg2", 64'(reg2_o), 64'(exp_reg[2]));
        end
        if (poke && i == 1 && k == 1) begin start_i = 1'b1; step_i = 1'b1; end
        if (k == 2) begin start_i = 1'b0; step_i = 1'b0; end
      end
      step_i = 1'b1; wr_data_i = 32'hD00D0000 + 32'(i);
      #1;
      check("R6 write strobe", 64'(mem_we_o && mem_req_o), 64'(wr_en));
      if (wr_en) begin
        check("R6 write address", 64'(mem_addr_o), 64'(ea(b[v.ws], s[v.ws], i)));
        check("R6 write data", 64'(mem_wdata_o), 64'(32'hD00D0000 + 32'(i)));
      end
      @(negedge clk); step_i = 1'b0;
      check("R5 valid falls after step", 64'(valid_o), 64'd0);
    end
    check("R8 done pulse", 64'({done_o, busy_o}), 64'b11);
    @(negedge clk);
    check("R8 idle after done", 64'({done_o, busy_o}), 64'b00);
  endtask

  initial begin
    #1;
    check("R1 reset outputs", 64'({busy_o, valid_o, done_o, mem_req_o, mem_we_o}), 64'd0);
    check("R1 reset regs", 64'(reg0_o | reg1_o | reg2_o), 64'd0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 idle after release", 64'({busy_o, valid_o, mem_req_o}), 64'd0);

    // R7 step while idle does nothing
    step_i = 1'b1; @(negedge clk); step_i = 1'b0;
    check("R7 step ignored when idle", 64'({busy_o, valid_o, mem_req_o}), 64'd0);

    // R8 zero count start ignored (count resets to 0)
    cfg_wr(4'd0, 32'h0000_0123);
    cfg_wr(4'd2, 32'd1);
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    check("R8 zero count start ignored", 64'({busy_o, mem_req_o}), 64'd0);

    // table-driven loops; vector 0 also pokes start/step mid-fetch (R7)
    for (int n = 0; n < 4; n++) run_vec(VEC[n], n == 0);

    // R1 asynchronous reset in the middle of a loop
    cfg_wr(4'd12, 32'd5);
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    @(negedge clk);
    rst_ni = 1'b0; #1;
    check("R1 reset mid-loop", 64'({busy_o, valid_o, done_o, mem_req_o}), 64'd0);
    check("R1 reset clears regs", 64'(reg0_o | reg1_o | reg2_o), 64'd0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    check("R9 count cleared by reset", 64'(busy_o), 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule